// File: doc/BRIEF.md
# Mode-Aware Parallel Data FIFO

This block is the byte queue behind the single data address of a parallel port. Its behaviour depends on the port mode. In the compatible forward-FIFO mode the host writes bytes in and the peripheral-side engine drains them. In the extended-capability mode the direction input sets which side fills the queue and which side empties it. In the diagnostic mode the host both writes and reads the queue. No handshake engine touches the queue in that mode, and the queue never stalls: a write to a full queue is thrown away, and a read of an empty queue returns the previous byte again.

The block reports full, empty and a service flag. The service flag compares the free space against a write threshold when the queue drains toward the peripheral. It compares the occupancy against a read threshold when the queue fills from the peripheral. The head byte is always visible to the peripheral side. In diagnostic mode the head byte is also driven onto a display output for the data lines. Any change of mode or direction flushes the queue.

Top module: `pfifo_mode_top`

## Requirements
- R1: With mode 3'b010 the direction input is ignored. `host_wr` enqueues `host_wdata` and `per_pop` dequeues. `host_rd` and `per_push` have no effect.
- R2: With mode 3'b011 and `dir`=0, `host_wr` enqueues `host_wdata` and `per_pop` dequeues. `host_rd` and `per_push` have no effect.
- R3: With mode 3'b011 and `dir`=1, `per_push` enqueues `per_wdata` and `host_rd` dequeues. `host_wr` and `per_pop` have no effect.
- R4: With mode 3'b110, `host_wr` enqueues and `host_rd` dequeues. `per_push` and `per_pop` have no effect.
- R5: Bytes leave in the order they entered. `per_rdata` shows the head byte whenever the queue is not empty. After the clock edge on which a host read dequeues a byte, `host_rdata` holds that byte.
- R6: An enqueue request while the queue holds DEPTH bytes is discarded. Occupancy and stored bytes stay unchanged, even when a dequeue happens in the same cycle.
- R7: A host read while the queue is empty leaves occupancy unchanged and leaves `host_rdata` at the last byte read.
- R8: `full` is 1 exactly when occupancy equals DEPTH, and `empty` is 1 exactly when occupancy is 0. An accepted enqueue and an accepted dequeue in the same cycle leave occupancy unchanged.
- R9: In the draining direction (mode 3'b010, or `dir`=0 in modes 3'b011 and 3'b110), `service` = (DEPTH − occupancy ≥ `wr_thresh`). In the filling direction (`dir`=1 in modes 3'b011 and 3'b110), `service` = (occupancy ≥ `rd_thresh`).
- R10: `disp_data` equals the head byte in mode 3'b110 when the queue is not empty, and is 0 otherwise.
- R11: On the clock edge on which `{mode,dir}` differs from its value at the previous edge, the queue empties, `host_rdata` becomes 0 and all strobes of that cycle are ignored.
- R12: In any other mode value, every strobe is ignored and `service` is 0.
- R13: After reset the queue is empty, `full` is 0 and `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Port mode code |
| dir | input | 1 | Direction: 0 toward peripheral, 1 toward host |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Last byte the host dequeued |
| per_push | input | 1 | Peripheral-side enqueue strobe |
| per_wdata | input | 8 | Peripheral-side enqueue byte |
| per_pop | input | 1 | Peripheral-side dequeue strobe |
| per_rdata | output | 8 | Head byte (show-ahead) |
| wr_thresh | input | $clog2(DEPTH+1) | Free-space threshold, draining direction |
| rd_thresh | input | $clog2(DEPTH+1) | Occupancy threshold, filling direction |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| service | output | 1 | Threshold reached |
| disp_data | output | 8 | Head byte for display in diagnostic mode |

## Verification
The bench sweeps every mode code and both directions over a range of thresholds. In each setting it drives every strobe at once, so that strobes which should have no effect are present and a routing mistake shows up at once as wrong occupancy or wrong data. Each fill runs two writes past full, so a design that accepted the extra bytes would later hand back data that was never in order, or report the wrong occupancy. Each drain runs two reads past empty, so a design that moved its read pointer would return a stale or wrong byte instead of repeating the last one. Every change of configuration is checked for a flush, which catches a queue that carries bytes across a direction switch or keeps an old `host_rdata`.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    localparam int BYTE_W = 8;

    localparam logic [2:0] MODE_STDFIFO = 3'b010;
    localparam logic [2:0] MODE_ECP     = 3'b011;
    localparam logic [2:0] MODE_TEST    = 3'b110;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_HOST   = 2'd1,
        SRC_PERIPH = 2'd2
    } src_e;

    // Decoded configuration: who may enqueue, who may dequeue, how the
    // service threshold is judged, and whether display is enabled.
    typedef struct packed {
        logic active;
        src_e push_src;
        src_e pop_src;
        logic drain_dir;
        logic test;
    } route_t;

    // One cycle's worth of queue operations after routing.
    typedef struct packed {
        logic  push;
        logic  pop;
        logic  host_pop;
        byte_t data;
    } op_t;

    function automatic route_t route_of(input logic [2:0] mode, input logic dir);
        route_t r;
        r.active    = 1'b0;
        r.push_src  = SRC_NONE;
        r.pop_src   = SRC_NONE;
        r.drain_dir = 1'b1;
        r.test      = 1'b0;
        case (mode)
            MODE_STDFIFO: begin
                r.active   = 1'b1;
                r.push_src = SRC_HOST;
                r.pop_src  = SRC_PERIPH;
            end
            MODE_ECP: begin
                r.active    = 1'b1;
                r.drain_dir = ~dir;
                if (dir) begin
                    r.push_src = SRC_PERIPH;
                    r.pop_src  = SRC_HOST;
                end else begin
                    r.push_src = SRC_HOST;
                    r.pop_src  = SRC_PERIPH;
                end
            end
            MODE_TEST: begin
                r.active    = 1'b1;
                r.push_src  = SRC_HOST;
                r.pop_src   = SRC_HOST;
                r.drain_dir = ~dir;
                r.test      = 1'b1;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfifo_route.sv
module pfifo_route
    import pfifo_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       dir,
    input  logic       flush,
    input  logic       host_wr,
    input  byte_t      host_wdata,
    input  logic       host_rd,
    input  logic       per_push,
    input  byte_t      per_wdata,
    input  logic       per_pop,
    output route_t     rt,
    output op_t        op
);

    always_comb begin
        rt = route_of(mode, dir);
        op.push = ~flush &
                  (((rt.push_src == SRC_HOST)   & host_wr) |
                   ((rt.push_src == SRC_PERIPH) & per_push));
        op.data = (rt.push_src == SRC_PERIPH) ? per_wdata : host_wdata;
        op.pop  = ~flush &
                  (((rt.pop_src == SRC_HOST)   & host_rd) |
                   ((rt.pop_src == SRC_PERIPH) & per_pop));
        op.host_pop = op.pop & (rt.pop_src == SRC_HOST);
    end

endmodule

// File: rtl/pfifo_store.sv
module pfifo_store
    import pfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  op_t           op,
    output byte_t         head,
    output logic [CW-1:0] count,
    output logic          pop_done
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    byte_t          mem [DEPTH];
    logic [AW-1:0]  wptr;
    logic [AW-1:0]  rptr;
    logic           can_push;
    logic           can_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign can_push = op.push & (count != FULL_CNT);
    assign can_pop  = op.pop  & (count != '0);
    assign pop_done = can_pop;
    assign head     = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (can_push) wptr <= bump(wptr);
            if (can_pop)  rptr <= bump(rptr);
            case ({can_push, can_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (can_push) mem[wptr] <= op.data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);  // R8

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (!flush && op.push && !op.pop && count == FULL_CNT)
        |=> (count == FULL_CNT && $stable(wptr)));  // R6

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!flush && op.pop && !op.push && count == '0)
        |=> (count == '0 && $stable(rptr)));  // R7

    AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!flush && op.push && op.pop && count != '0 && count != FULL_CNT)
        |=> $stable(count));  // R8

endmodule

// File: rtl/pfifo_flags.sv
module pfifo_flags
    import pfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  route_t        rt,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] wr_thresh,
    input  logic [CW-1:0] rd_thresh,
    output logic          full,
    output logic          empty,
    output logic          service
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CW-1:0] free_slots;

    always_comb begin
        free_slots = FULL_CNT - count;
        full       = (count == FULL_CNT);
        empty      = (count == '0);
        if (!rt.active)
            service = 1'b0;
        else if (rt.drain_dir)
            service = (free_slots >= wr_thresh);
        else
            service = (count >= rd_thresh);
    end

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));  // R8

    AST_SVC_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rt.active && rt.drain_dir && empty && wr_thresh <= FULL_CNT) |-> service);  // R9

    AST_SVC_FULL: assert property (@(posedge clk) disable iff (rst)
        (rt.active && !rt.drain_dir && full && rd_thresh <= FULL_CNT) |-> service);  // R9

endmodule

// File: rtl/pfifo_mode_top.sv
module pfifo_mode_top
    import pfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    mode,
    input  logic          dir,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    input  logic          host_rd,
    output logic [7:0]    host_rdata,
    input  logic          per_push,
    input  logic [7:0]    per_wdata,
    input  logic          per_pop,
    output logic [7:0]    per_rdata,
    input  logic [CW-1:0] wr_thresh,
    input  logic [CW-1:0] rd_thresh,
    output logic          full,
    output logic          empty,
    output logic          service,
    output logic [7:0]    disp_data
);

    logic [3:0]    cfg_q;
    logic          flush;
    route_t        rt;
    op_t           op;
    byte_t         head;
    logic [CW-1:0] count;
    logic          pop_done;
    byte_t         last_rd;

    assign flush = ~rst & (cfg_q != {mode, dir});

    always_ff @(posedge clk) begin
        cfg_q <= {mode, dir};
    end

    pfifo_route u_route (
        .mode       (mode),
        .dir        (dir),
        .flush      (flush),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .per_push   (per_push),
        .per_wdata  (per_wdata),
        .per_pop    (per_pop),
        .rt         (rt),
        .op         (op)
    );

    pfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .op       (op),
        .head     (head),
        .count    (count),
        .pop_done (pop_done)
    );

    pfifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .rt        (rt),
        .count     (count),
        .wr_thresh (wr_thresh),
        .rd_thresh (rd_thresh),
        .full      (full),
        .empty     (empty),
        .service   (service)
    );

    always_ff @(posedge clk) begin
        if (rst || flush)
            last_rd <= '0;
        else if (pop_done && op.host_pop)
            last_rd <= head;
    end

    assign host_rdata = last_rd;
    assign per_rdata  = head;
    assign disp_data  = (rt.test && !empty) ? head : '0;

    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flush |=> (empty && host_rdata == 8'h00));  // R11

    AST_REREAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op.host_pop && empty) |=> $stable(host_rdata));  // R7

    AST_STD_HOSTRD_IGN: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STDFIFO && !flush && host_rd) |=> $stable(host_rdata));  // R1

    AST_DISP_HEAD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TEST && !empty) |-> (disp_data == per_rdata));  // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!rt.active && !flush) |=> ($stable(empty) && $stable(host_rdata)));  // R12

endmodule

// File: tb/sim_pfifo_mode_top.sv
module sim_pfifo_mode_top;

    localparam int DEPTH = 4;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    mode = 3'd0;
    logic          dir = 1'b0;
    logic          host_wr = 1'b0;
    logic [7:0]    host_wdata = 8'h00;
    logic          host_rd = 1'b0;
    logic [7:0]    host_rdata;
    logic          per_push = 1'b0;
    logic [7:0]    per_wdata = 8'h00;
    logic          per_pop = 1'b0;
    logic [7:0]    per_rdata;
    logic [CW-1:0] wr_thresh = '0;
    logic [CW-1:0] rd_thresh = '0;
    logic          full;
    logic          empty;
    logic          service;
    logic [7:0]    disp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] mq[$];
    logic [7:0] m_last = 8'h00;
    logic [3:0] m_cfg = 4'h0;
    logic [7:0] dcnt = 8'h01;
    logic [7:0] lf = 8'h5a;

    always #2 clk = ~clk;

    pfifo_mode_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .dir(dir),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .per_push(per_push), .per_wdata(per_wdata),
        .per_pop(per_pop), .per_rdata(per_rdata), .wr_thresh(wr_thresh),
        .rd_thresh(rd_thresh), .full(full), .empty(empty), .service(service),
        .disp_data(disp_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string mtag(input logic [2:0] m, input logic d);
        if (m == 3'b010) return "R1";
        if (m == 3'b011 && !d) return "R2";
        if (m == 3'b011) return "R3";
        if (m == 3'b110) return "R4";
        return "R12";
    endfunction

    task automatic step(input logic [2:0] m, input logic d,
                        input logic hw, input logic hr,
                        input logic pp, input logic pq);
        int psrc = 0;
        int qsrc = 0;
        int sz;
        bit flush = 0;
        bit dropped = 0;
        bit reread = 0;
        bit act;
        bit drain;
        logic [7:0] hdat = dcnt;
        logic [7:0] pdat = ~dcnt;
        logic [7:0] b;
        string tg;

        dcnt = dcnt + 8'd1;
        mode = m; dir = d;
        host_wr = hw; host_rd = hr; per_push = pp; per_pop = pq;
        host_wdata = hdat; per_wdata = pdat;

        act   = (m == 3'b010) || (m == 3'b011) || (m == 3'b110);
        drain = (m == 3'b010) || ((m == 3'b011 || m == 3'b110) && !d);
        if ({m, d} != m_cfg) begin
            flush = 1;
            mq.delete();
            m_last = 8'h00;
            m_cfg = {m, d};
        end else begin
            if (m == 3'b010 || (m == 3'b011 && !d)) begin
                psrc = hw ? 1 : 0; qsrc = pq ? 2 : 0;
            end else if (m == 3'b011) begin
                psrc = pp ? 2 : 0; qsrc = hr ? 1 : 0;
            end else if (m == 3'b110) begin
                psrc = hw ? 1 : 0; qsrc = hr ? 1 : 0;
            end
            sz = mq.size();
            if (psrc != 0 && sz == DEPTH) dropped = 1;
            if (qsrc == 1 && sz == 0) reread = 1;
            if (qsrc != 0 && sz > 0) begin
                b = mq.pop_front();
                if (qsrc == 1) m_last = b;
            end
            if (psrc != 0 && sz < DEPTH)
                mq.push_back(psrc == 1 ? hdat : pdat);
        end

        @(negedge clk);
        host_wr = 0; host_rd = 0; per_push = 0; per_pop = 0;

        sz = mq.size();
        tg = flush ? "R11" : mtag(m, d);
        chk(dropped ? "R6" : "R8", "full", full, sz == DEPTH);
        chk(flush ? "R11" : "R8", "empty", empty, sz == 0);
        chk(reread ? "R7" : (flush ? "R11" : "R5"), "host_rdata", host_rdata, m_last);
        if (sz > 0) chk(tg, "per_rdata", per_rdata, mq[0]);
        chk(act ? "R9" : "R12", "service", service,
            act && (drain ? ((DEPTH - sz) >= int'(wr_thresh)) : (sz >= int'(rd_thresh))));
        chk("R10", "disp_data", disp_data, (m == 3'b110 && sz > 0) ? mq[0] : 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R13", "empty after reset", empty, 1);
        chk("R13", "full after reset", full, 0);
        chk("R13", "host_rdata after reset", host_rdata, 8'h00);

        for (int mi = 0; mi < 8; mi++) begin
            for (int di = 0; di < 2; di++) begin
                for (int t = 0; t <= DEPTH; t++) begin
                    wr_thresh = CW'(t);
                    rd_thresh = CW'(DEPTH - t);
                    // fill past full with every enqueue strobe raised
                    for (int k = 0; k < DEPTH + 2; k++)
                        step(3'(mi), 1'(di), 1, 0, 1, 0);
                    // drain past empty with every dequeue strobe raised
                    for (int k = 0; k < DEPTH + 2; k++)
                        step(3'(mi), 1'(di), 0, 1, 0, 1);
                    // mixed pattern, simultaneous enqueue and dequeue
                    for (int k = 0; k < 6; k++) begin
                        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                        step(3'(mi), 1'(di), lf[0], lf[1], lf[2], lf[3]);
                    end
                end
            end
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule